// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block is a bus master that turns single internal read or write requests into cycles on an external memory bus. The low byte of the 16-bit address and the 8-bit data share one AD bus, with a separate output enable so the pad can float it. The high address byte has its own dedicated outputs. Each cycle moves through three fixed states, T1, T2 and T3. Wait states can be inserted between T2 and T3 by pulling an active-low wait input low. An extended-timing option adds two clock periods to every cycle.

Internally a request is presented with an address, a direction flag, write data, a memory-space flag and an extended-timing flag. The controller returns a one-cycle done pulse, and read data with it. Only one request is in flight at a time. Requests seen while a cycle runs are dropped.

Top module: `mxbus_ctrl`

## Requirements
- R1: After synchronous reset, and whenever idle, as_n and ds_n are 1, ad_oe is 0, done is 0 and rw is 1 (1 means read, 0 means write).
- R2: In T1, the first cycle after a request is accepted while idle, as_n is 0, ds_n is 1, ad_oe is 1, ad_out carries address bits 7..0, addr_hi carries address bits 15..8, and space_sel carries the request's space flag.
- R3: From T2 until ds_n rises, as_n is 1 and ds_n is 0. On a read, ad_oe is 0 from T2 through T3.
- R4: On a write, ad_oe is 1 and ad_out carries the write data from T2 through T3 inclusive, so the data is held after ds_n rises.
- R5: On a read, ad_in is captured on the clock edge at which ds_n rises. It is presented on rdata in the cycle where done is 1 and holds there until the next read.
- R6: done is a single-cycle pulse in T3 with as_n and ds_n both 1. Without waits or extended timing, a cycle lasts exactly 3 clocks, T1 to T3.
- R7: wait_n is sampled on the clock edge that ends the last T2 clock and on each edge that ends a TW. Every low sample adds one TW clock with ds_n still 0, and consecutive wait states are allowed.
- R8: wait_n is ignored in T1 and T3; a low level there does not change the cycle length.
- R9: With ext_timing set on the request, T2 lasts 3 clocks instead of 1, so a cycle without waits takes 5 clocks.
- R10: Requests are accepted only while idle. A request held or changed during a running cycle does not alter it. At least one idle clock separates consecutive cycles.
- R11: rw and addr_hi stay constant from T1 through T3.
- R12: Reset asserted in the middle of a cycle returns all outputs to the idle values of R1 on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request strobe, taken only while idle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write data |
| req_space | input | 1 | Memory space flag copied to space_sel |
| ext_timing | input | 1 | Extended timing for this request |
| rdata | output | 8 | Read data |
| done | output | 1 | Cycle completion pulse |
| as_n | output | 1 | Address strobe, active low |
| ds_n | output | 1 | Data strobe, active low |
| rw | output | 1 | Bus direction, 1 read, 0 write |
| ad_out | output | 8 | Driven value of the shared AD bus |
| ad_oe | output | 1 | AD bus drive enable |
| ad_in | input | 8 | Sampled value of the shared AD bus |
| addr_hi | output | 8 | Upper address byte |
| space_sel | output | 1 | Memory space select |
| wait_n | input | 1 | Wait request, active low |

## Verification
Reads and writes are each run plain, with one and with several wait states, and with extended timing, alone and combined with waits. The measured length separates the T2 stretch from wait insertion. The memory model drives the AD bus with one byte while ds_n is low and with its complement otherwise, so a capture on the wrong edge returns the wrong value. In one case wait_n is held low in T1 and T3 to show that it is sampled only in T2 and TW. In another, the request is kept asserted with a changing address through a whole cycle to show that it is ignored. A reset in T2 checks the recovery to idle.

// File: rtl/mxbus_ctrl.sv
module mxbus_ctrl #(
  parameter int AW      = 16,
  parameter int DW      = 8,
  parameter int EXT_CYC = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          req_space,
  input  logic          ext_timing,
  output logic [DW-1:0] rdata,
  output logic          done,
  output logic          as_n,
  output logic          ds_n,
  output logic          rw,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  input  logic [DW-1:0] ad_in,
  output logic [AW-DW-1:0] addr_hi,
  output logic          space_sel,
  input  logic          wait_n
);
  localparam int XW = $clog2(EXT_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_T1, S_T2, S_TW, S_T3} st_t;

  st_t            st;
  logic [AW-1:0]  a_q;
  logic [DW-1:0]  wd_q, rd_q;
  logic           we_q, sp_q, ext_q;
  logic [XW-1:0]  xcnt;
  logic           t2_last, busy, strobe;

  assign t2_last = (xcnt == (ext_q ? XW'(EXT_CYC) : '0));

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= S_IDLE;
      a_q   <= '0;
      wd_q  <= '0;
      rd_q  <= '0;
      we_q  <= 1'b0;
      sp_q  <= 1'b0;
      ext_q <= 1'b0;
      xcnt  <= '0;
    end else begin
      case (st)
        S_IDLE: if (req) begin
          st    <= S_T1;
          a_q   <= req_addr;
          wd_q  <= req_wdata;
          we_q  <= req_we;
          sp_q  <= req_space;
          ext_q <= ext_timing;
        end
        S_T1: begin
          st   <= S_T2;
          xcnt <= '0;
        end
        S_T2: begin
          if (!t2_last) xcnt <= xcnt + 1'b1;
          else if (!wait_n) st <= S_TW;
          else begin
            st <= S_T3;
            if (!we_q) rd_q <= ad_in;
          end
        end
        S_TW: if (wait_n) begin
          st <= S_T3;
          if (!we_q) rd_q <= ad_in;
        end
        S_T3:    st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy      = (st != S_IDLE);
  assign strobe    = (st == S_T2) || (st == S_TW);
  assign as_n      = (st != S_T1);
  assign ds_n      = !strobe;
  assign done      = (st == S_T3);
  assign rw        = busy ? !we_q : 1'b1;
  assign ad_oe     = (st == S_T1) || (we_q && (strobe || st == S_T3));
  assign ad_out    = (st == S_T1) ? a_q[DW-1:0] : wd_q;
  assign addr_hi   = a_q[AW-1:DW];
  assign space_sel = sp_q;
  assign rdata     = rd_q;

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!as_n && !ds_n));

  // R3
  as_then_ds_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(as_n) |=> (as_n && !ds_n));

  // R3
  read_float_chk: assert property (@(posedge clk) disable iff (rst)
    (!ds_n && rw) |-> !ad_oe);

  // R6
  done_after_ds_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(!ds_n) && ds_n && as_n));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R11
  rw_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ds_n |-> ($stable(rw) && $stable(addr_hi)));
endmodule

// File: tb/mxbus_ctrl_tb.sv
module mxbus_ctrl_tb;
  logic        clk = 0, rst = 1;
  logic        req = 0, req_we = 0, req_space = 0, ext_timing = 0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0, ad_in = '0;
  logic        wait_n = 1;
  logic [7:0]  rdata, ad_out, addr_hi;
  logic        done, as_n, ds_n, rw, ad_oe, space_sel;
  int nt = 0, nf = 0;

  always #5 clk = ~clk;

  mxbus_ctrl u_dut (
    .clk(clk), .rst(rst), .req(req), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_space(req_space), .ext_timing(ext_timing),
    .rdata(rdata), .done(done), .as_n(as_n), .ds_n(ds_n), .rw(rw),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .addr_hi(addr_hi),
    .space_sel(space_sel), .wait_n(wait_n)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nt++;
    if (!ok) begin
      nf++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk(as_n == 1'b1, tag, as_n, 1);
    chk(ds_n == 1'b1, tag, ds_n, 1);
    chk(ad_oe == 1'b0, tag, ad_oe, 0);
    chk(done == 1'b0, tag, done, 0);
    chk(rw == 1'b1, tag, rw, 1);
  endtask

  task automatic run_cycle(input logic [15:0] addr, input bit we, input logic [7:0] wd,
                           input logic [7:0] rv, input bit sp, input bit ext,
                           input int nwait, input bit wait_edges, input bit spam);
    int t2end = ext ? 3 : 1;
    int len   = 3 + (ext ? 2 : 0) + nwait;
    string ts = wait_edges ? "R8" : (nwait > 0) ? "R7" : ext ? "R9" : "R3";
    string th = spam ? "R10" : "R11";
    req_addr = addr; req_we = we; req_wdata = wd; req_space = sp; ext_timing = ext;
    req = 1;
    for (int c = 0; c < len; c++) begin
      @(negedge clk);
      if (spam) begin
        req_addr = addr ^ 16'hFFFF; req_we = !we; req_space = !sp; ext_timing = !ext;
        req = (c != len - 1);
      end else if (c == 0) req = 0;
      wait_n = !((c >= t2end && c < t2end + nwait) ||
                 (wait_edges && (c == 0 || c == len - 1)));
      ad_in  = (c >= 1 && c <= len - 2) ? rv : ~rv;
      if (c == 0) begin
        chk(as_n == 0, "R2", as_n, 0);
        chk(ds_n == 1, "R2", ds_n, 1);
        chk(ad_oe == 1, "R2", ad_oe, 1);
        chk(ad_out == addr[7:0], "R2", ad_out, addr[7:0]);
        chk(addr_hi == addr[15:8], "R2", addr_hi, addr[15:8]);
        chk(space_sel == sp, "R2", space_sel, sp);
        chk(rw == !we, "R11", rw, !we);
      end else if (c < len - 1) begin
        chk(as_n == 1, ts, as_n, 1);
        chk(ds_n == 0, ts, ds_n, 0);
        chk(done == 0, ts, done, 0);
        chk(ad_oe == we, we ? "R4" : "R3", ad_oe, we);
        if (we) chk(ad_out == wd, "R4", ad_out, wd);
        chk(addr_hi == addr[15:8], th, addr_hi, addr[15:8]);
        chk(rw == !we, th, rw, !we);
      end else begin
        chk(done == 1, ts, done, 1);
        chk(ds_n == 1 && as_n == 1, "R6", {ds_n, as_n}, 3);
        chk(rw == !we, th, rw, !we);
        chk(addr_hi == addr[15:8], th, addr_hi, addr[15:8]);
        if (we) chk(ad_oe == 1 && ad_out == wd, "R4", {ad_oe, ad_out}, {1'b1, wd});
        else begin
          chk(ad_oe == 0, "R3", ad_oe, 0);
          chk(rdata == rv, "R5", rdata, rv);
        end
      end
    end
    req = 0; wait_n = 1;
    @(negedge clk);
    chk_idle(spam ? "R10" : "R1");
    chk(done == 0, "R6", done, 0);
    if (!we) chk(rdata == rv, "R5", rdata, rv);
    @(negedge clk);
    chk(as_n == 1, spam ? "R10" : "R1", as_n, 1);
  endtask

  task automatic test_mid_reset();
    req_addr = 16'h1234; req_we = 1; req_wdata = 8'h77; ext_timing = 1; req = 1;
    @(negedge clk); req = 0;
    @(negedge clk);
    chk(ds_n == 0, "R12", ds_n, 0);
    rst = 1;
    @(negedge clk);
    chk_idle("R12");
    rst = 0;
    @(negedge clk);
    chk_idle("R12");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nf++;
    $display("watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nt, nf);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_idle("R1");
    rst = 0;
    @(negedge clk);
    chk_idle("R1");
    run_cycle(16'hA55A, 0, 8'h00, 8'h3C, 0, 0, 0, 0, 0);
    run_cycle(16'h12F0, 1, 8'hC3, 8'h00, 1, 0, 0, 0, 0);
    run_cycle(16'h8001, 0, 8'h00, 8'h96, 1, 0, 1, 0, 0);
    run_cycle(16'h4E21, 1, 8'h5A, 8'h00, 0, 0, 4, 0, 0);
    run_cycle(16'hFF00, 0, 8'h00, 8'h81, 0, 1, 0, 0, 0);
    run_cycle(16'h00FF, 1, 8'hE7, 8'h00, 1, 1, 3, 0, 0);
    run_cycle(16'h7654, 0, 8'h00, 8'h42, 0, 0, 0, 1, 0);
    run_cycle(16'h3C3C, 0, 8'h00, 8'h18, 1, 0, 2, 0, 1);
    run_cycle(16'hC001, 1, 8'hA1, 8'h00, 0, 1, 0, 0, 1);
    test_mid_reset();
    run_cycle(16'h0102, 0, 8'h00, 8'hF5, 0, 0, 0, 0, 0);
    $display("[TB] %0d tests run, %0d failed", nt, nf);
    $finish;
  end
endmodule